// File: doc/BRIEF.md
# Channel Set/Clear Status Bank

This block is the control and status register bank for an 18-channel DMA controller. For every channel it holds an enable bit, an interrupt-enable bit and three sticky event flags: completion A, completion B and error. Software reaches the bank through a simple word-addressed register bus. Masks are changed through separate write-one-to-set and write-one-to-clear addresses, and sticky flags are cleared by writing ones, so software never needs a read-modify-write sequence.

The channel engines report completions and errors as single-cycle pulses. The bank stores these pulses as sticky flags. From the flags it builds a global status word that keeps normal and error interrupts apart, and it drives one combined interrupt line. Writes to the command addresses produce one-cycle per-channel strobes for abort, set-valid and set-trigger.

Top module: `dma_chan_regbank`

## Requirements
- R1: After reset every channel mask, sticky flag and strobe is zero, the controller enable is zero and `irq` is low.
- R2: Writing word address 2 with a 1 in bit n enables channel n. Writing word address 3 with a 1 in bit n disables it. A 0 bit changes nothing. Reading address 2 returns the enable mask, which is also driven on `ch_en`.
- R3: Interrupt enables work the same way. Address 6 sets bits and reads back the mask. Address 7 clears bits and is write-only.
- R4: A pulse on `done_a`, `done_b` or `err_pls` bit n sets the sticky flag for channel n. The flag sets are read at addresses 8, 9 and 5 respectively. Writing a 1 to a bit at that address clears the flag, and a 0 bit leaves it unchanged.
- R5: If a flag's set pulse and a clear write for the same bit arrive in the same cycle, the flag ends up set.
- R6: Global status (address 1) has bit 1 high when any channel with its interrupt enable set has an A or B flag pending. Bit 2 is high when any error flag is set, whatever the interrupt enables hold.
- R7: `irq` equals the OR of status bits 1 and 2.
- R8: Control (address 0) bit 0 is read/write and drives `ctrl_en`. Its other bits read as zero.
- R9: Writing address 10 (set-valid), 11 (set-trigger) or 12 (abort) raises `valid_stb`, `trig_stb` or `abort_stb` on exactly the written bits. The strobe is high for the one cycle after the write edge and is zero otherwise.
- R10: Bits 18 to 31 of every read are zero. The write-only addresses 3, 7, 10, 11 and 12 and the unused addresses 13 to 15 read as zero.
- R11: Address 4 reads back the per-channel `ch_busy` inputs, so software can wait for a channel to go idle before aborting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| done_a | input | 18 | Per-channel completion A pulses |
| done_b | input | 18 | Per-channel completion B pulses |
| err_pls | input | 18 | Per-channel error pulses |
| ch_busy | input | 18 | Per-channel busy status from the engines |
| ctrl_en | output | 1 | Controller enable |
| ch_en | output | 18 | Per-channel enable mask |
| abort_stb | output | 18 | One-cycle abort strobes |
| valid_stb | output | 18 | One-cycle set-valid strobes |
| trig_stb | output | 18 | One-cycle set-trigger strobes |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the same-cycle collision of a flag pulse and its clear write. A design that gives the clear priority would lose the event, and the flag would read back as zero. It checks that the error summary ignores the interrupt enables while the A/B summary respects them. A design that mixed up the two would raise or hide `irq` wrongly. Writes of zero to set and clear addresses, and writes with data in bits 18 to 31, are checked to have no effect; a design that decoded too many bits would show stray mask bits. Strobes are compared on every clock, so a strobe that stays high for two cycles, or that fires on a read, is caught.

// File: rtl/chanbank_pkg.sv
package chanbank_pkg;
  localparam int AW = 4;

  typedef enum logic [AW-1:0] {
    RA_CTRL    = 4'd0,
    RA_GSTAT   = 4'd1,
    RA_EN_SET  = 4'd2,
    RA_EN_CLR  = 4'd3,
    RA_BUSY    = 4'd4,
    RA_ERR     = 4'd5,
    RA_IE_SET  = 4'd6,
    RA_IE_CLR  = 4'd7,
    RA_FLAG_A  = 4'd8,
    RA_FLAG_B  = 4'd9,
    RA_VALID   = 4'd10,
    RA_TRIG    = 4'd11,
    RA_ABORT   = 4'd12
  } reg_addr_e;

  localparam int GS_INT_BIT = 1;
  localparam int GS_ERR_BIT = 2;
endpackage

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (set_we) mask <= mask | bits;
    else if (clr_we) mask <= mask & ~bits;
  end

  // R2 (and R3, which reuses this module)
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask & $past(bits)) == $past(bits)));
  a_r2_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((mask & $past(bits)) == '0));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask));
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_pls,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flags
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | set_pls;
  end

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pls) |=> ((flags & $past(set_pls)) == $past(set_pls)));
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_pls == '0) && !clr_we) |=> $stable(flags));
  a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flags & $past(clr_bits & ~set_pls)) == '0));
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] strb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb <= '0;
    else        strb <= we ? bits : '0;
  end

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (strb == '0));
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
  import chanbank_pkg::*;
#(
  parameter int NCH = 18,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] done_a,
  input  logic [NCH-1:0] done_b,
  input  logic [NCH-1:0] err_pls,
  input  logic [NCH-1:0] ch_busy,
  output logic           ctrl_en,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] abort_stb,
  output logic [NCH-1:0] valid_stb,
  output logic [NCH-1:0] trig_stb,
  output logic           irq
);
  localparam int NSTB = 3;

  function automatic logic [DW-1:0] widen(input logic [NCH-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[NCH-1:0] = v;
    return r;
  endfunction

  function automatic logic int_summary(input logic [NCH-1:0] ie,
                                       input logic [NCH-1:0] fa,
                                       input logic [NCH-1:0] fb);
    return |(ie & (fa | fb));
  endfunction

  // write decode, brought out as named wires
  logic           wr_go;
  logic [NCH-1:0] wbits;
  logic we_ctrl, we_en_set, we_en_clr, we_ie_set, we_ie_clr;
  logic we_err, we_fa, we_fb, we_valid, we_trig, we_abort;

  assign wr_go     = bus_sel & bus_wr;
  assign wbits     = bus_wdata[NCH-1:0];
  assign we_ctrl   = wr_go && (bus_addr == RA_CTRL);
  assign we_en_set = wr_go && (bus_addr == RA_EN_SET);
  assign we_en_clr = wr_go && (bus_addr == RA_EN_CLR);
  assign we_ie_set = wr_go && (bus_addr == RA_IE_SET);
  assign we_ie_clr = wr_go && (bus_addr == RA_IE_CLR);
  assign we_err    = wr_go && (bus_addr == RA_ERR);
  assign we_fa     = wr_go && (bus_addr == RA_FLAG_A);
  assign we_fb     = wr_go && (bus_addr == RA_FLAG_B);
  assign we_valid  = wr_go && (bus_addr == RA_VALID);
  assign we_trig   = wr_go && (bus_addr == RA_TRIG);
  assign we_abort  = wr_go && (bus_addr == RA_ABORT);

  // controller enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_en <= 1'b0;
    else if (we_ctrl) ctrl_en <= bus_wdata[0];
  end

  // masks
  logic [NCH-1:0] ie_q;

  mask_reg #(.W(NCH)) u_en (
    .clk(clk), .rst_n(rst_n), .set_we(we_en_set), .clr_we(we_en_clr),
    .bits(wbits), .mask(ch_en));

  mask_reg #(.W(NCH)) u_ie (
    .clk(clk), .rst_n(rst_n), .set_we(we_ie_set), .clr_we(we_ie_clr),
    .bits(wbits), .mask(ie_q));

  // sticky flags
  logic [NCH-1:0] fa_q, fb_q, err_q;

  sticky_bank #(.W(NCH)) u_fa (
    .clk(clk), .rst_n(rst_n), .set_pls(done_a), .clr_we(we_fa),
    .clr_bits(wbits), .flags(fa_q));

  sticky_bank #(.W(NCH)) u_fb (
    .clk(clk), .rst_n(rst_n), .set_pls(done_b), .clr_we(we_fb),
    .clr_bits(wbits), .flags(fb_q));

  sticky_bank #(.W(NCH)) u_err (
    .clk(clk), .rst_n(rst_n), .set_pls(err_pls), .clr_we(we_err),
    .clr_bits(wbits), .flags(err_q));

  // command strobes
  logic [NSTB-1:0]          stb_we;
  logic [NSTB-1:0][NCH-1:0] stb_q;

  assign stb_we = {we_abort, we_trig, we_valid};

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    strobe_gen #(.W(NCH)) u_stb (
      .clk(clk), .rst_n(rst_n), .we(stb_we[g]), .bits(wbits),
      .strb(stb_q[g]));
  end

  assign valid_stb = stb_q[0];
  assign trig_stb  = stb_q[1];
  assign abort_stb = stb_q[2];

  // summary and interrupt
  logic          sum_int, sum_err;
  logic [DW-1:0] gstat;

  assign sum_int = int_summary(ie_q, fa_q, fb_q);
  assign sum_err = |err_q;

  always_comb begin
    gstat = '0;
    gstat[GS_INT_BIT] = sum_int;
    gstat[GS_ERR_BIT] = sum_err;
  end

  assign irq = gstat[GS_INT_BIT] | gstat[GS_ERR_BIT];

  // read mux
  always_comb begin
    case (bus_addr)
      RA_CTRL:   bus_rdata = widen({{(NCH-1){1'b0}}, ctrl_en});
      RA_GSTAT:  bus_rdata = gstat;
      RA_EN_SET: bus_rdata = widen(ch_en);
      RA_BUSY:   bus_rdata = widen(ch_busy);
      RA_ERR:    bus_rdata = widen(err_q);
      RA_IE_SET: bus_rdata = widen(ie_q);
      RA_FLAG_A: bus_rdata = widen(fa_q);
      RA_FLAG_B: bus_rdata = widen(fb_q);
      default:   bus_rdata = '0;
    endcase
  end

  // checks across the sub-blocks
  a_r7_err_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_q) |-> irq);
  a_r6_quiet_without_ie: assert property (@(posedge clk) disable iff (!rst_n)
    ((ie_q == '0) && (err_q == '0)) |-> !irq);
  a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ctrl |=> $stable(ctrl_en));
  a_r9_abort_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|abort_stb) |-> $past(we_abort));
  a_r9_onehot_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_we));

  if (NCH < DW) begin : g_hi
    a_r10_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DW-1:NCH] == '0);
  end
endmodule

// File: tb/dma_chan_regbank_test.sv
`timescale 1ns/1ps
module dma_chan_regbank_test;
  localparam int NCH = 18;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]     bus_addr = '0;
  logic [DW-1:0]  bus_wdata = '0;
  logic [DW-1:0]  bus_rdata;
  logic [NCH-1:0] done_a = '0, done_b = '0, err_pls = '0, ch_busy = '0;
  logic           ctrl_en, irq;
  logic [NCH-1:0] ch_en, abort_stb, valid_stb, trig_stb;

  int total = 0;
  int bad = 0;
  int cyc_cnt = 0;

  always #2.5 clk = ~clk;

  dma_chan_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_a(done_a), .done_b(done_b), .err_pls(err_pls), .ch_busy(ch_busy),
    .ctrl_en(ctrl_en), .ch_en(ch_en), .abort_stb(abort_stb),
    .valid_stb(valid_stb), .trig_stb(trig_stb), .irq(irq));

  // behavioural reference model
  bit        m_ctrl;
  bit [17:0] m_en, m_ie, m_a, m_b, m_err, m_val, m_trg, m_abt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_en = 0; m_ie = 0; m_a = 0; m_b = 0; m_err = 0;
      m_val = 0; m_trg = 0; m_abt = 0;
    end else begin
      bit [17:0] d;
      d = bus_wdata[17:0];
      m_val = 0; m_trg = 0; m_abt = 0;
      if (bus_sel && bus_wr) begin
        case (int'(bus_addr))
          0:  m_ctrl = bus_wdata[0];
          2:  m_en  = m_en | d;
          3:  m_en  = m_en & ~d;
          5:  m_err = m_err & ~d;
          6:  m_ie  = m_ie | d;
          7:  m_ie  = m_ie & ~d;
          8:  m_a   = m_a & ~d;
          9:  m_b   = m_b & ~d;
          10: m_val = d;
          11: m_trg = d;
          12: m_abt = d;
          default: ;
        endcase
      end
      m_a   = m_a | done_a;
      m_b   = m_b | done_b;
      m_err = m_err | err_pls;
    end
  end

  function automatic bit m_int();
    return (m_ie & (m_a | m_b)) != 0;
  endfunction

  function automatic bit [31:0] m_read(input int a);
    case (a)
      0: return {31'b0, m_ctrl};
      1: return {29'b0, (m_err != 0), m_int(), 1'b0};
      2: return {14'b0, m_en};
      4: return {14'b0, ch_busy};
      5: return {14'b0, m_err};
      6: return {14'b0, m_ie};
      8: return {14'b0, m_a};
      9: return {14'b0, m_b};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, before the drivers move
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ch_en", {14'b0, ch_en}, {14'b0, m_en});
      chk("R8 ctrl_en", {31'b0, ctrl_en}, {31'b0, m_ctrl});
      chk("R9 valid_stb", {14'b0, valid_stb}, {14'b0, m_val});
      chk("R9 trig_stb", {14'b0, trig_stb}, {14'b0, m_trg});
      chk("R9 abort_stb", {14'b0, abort_stb}, {14'b0, m_abt});
      chk("R7 irq", {31'b0, irq}, {31'b0, m_int() | (m_err != 0)});
    end
  end

  task automatic cyc(input bit sel, input bit wr, input int a, input logic [31:0] wd,
                     input logic [17:0] pa, input logic [17:0] pb, input logic [17:0] pe);
    @(negedge clk);
    #0.5;
    bus_sel = sel; bus_wr = wr; bus_addr = a[3:0]; bus_wdata = wd;
    done_a = pa; done_b = pb; err_pls = pe;
  endtask

  task automatic wr(input int a, input logic [31:0] wd);
    cyc(1, 1, a, wd, 0, 0, 0);
  endtask

  task automatic rd(input string tag, input int a);
    cyc(1, 0, a, 0, 0, 0, 0);
    #0.5;
    chk(tag, bus_rdata, m_read(a));
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R10: reset state, every address reads zero
    for (int a = 0; a < 16; a++) begin
      rd("R1 reset read", a);
      chk("R1 reset value", bus_rdata, 32'h0);
    end
    chk("R1 irq low", {31'b0, irq}, 32'h0);

    // R2: set / clear enables, zero writes, high bits ignored
    wr(2, 32'hFFFC_0005);
    rd("R2 en after set", 2);
    chk("R10 high bits zero", bus_rdata, 32'h0000_0005);
    wr(3, 32'h0000_0001);
    rd("R2 en after clr", 2);
    chk("R2 en value", bus_rdata, 32'h0000_0004);
    wr(2, 0); wr(3, 0);
    rd("R2 zero writes", 2);
    chk("R2 zero no effect", bus_rdata, 32'h0000_0004);
    rd("R10 clr reads zero", 3);

    // R3: interrupt enables
    wr(6, 32'h0000_0018);
    wr(7, 32'h0000_0010);
    rd("R3 ie mask", 6);
    chk("R3 ie value", bus_rdata, 32'h0000_0008);
    rd("R10 ie clr reads zero", 7);

    // R4 / R6: A flag on an enabled channel raises bit 1
    cyc(0, 0, 0, 0, 18'h00008, 0, 0);
    idle();
    rd("R4 flag A", 8);
    rd("R6 gstat int", 1);
    chk("R6 gstat int value", bus_rdata, 32'h2);
    // B flag on a channel without interrupt enable: no summary
    wr(8, 32'h8);
    cyc(0, 0, 0, 0, 0, 18'h00020, 0);
    idle();
    rd("R4 flag B", 9);
    rd("R6 gstat masked", 1);
    chk("R6 masked value", bus_rdata, 32'h0);

    // R5: clear and set of the same bit in one cycle
    cyc(1, 1, 9, 32'h20, 0, 18'h00020, 0);
    idle();
    rd("R5 set wins", 9);
    chk("R5 set wins value", bus_rdata, 32'h20);
    wr(9, 32'h20);
    rd("R4 B cleared", 9);
    chk("R4 B cleared value", bus_rdata, 32'h0);

    // R6 / R7: error flag ignores interrupt enables
    cyc(0, 0, 0, 0, 0, 0, 18'h20000);
    idle();
    rd("R6 gstat err", 1);
    chk("R6 err value", bus_rdata, 32'h4);
    chk("R7 irq on err", {31'b0, irq}, 32'h1);
    wr(5, 32'h20000);
    rd("R4 err cleared", 5);

    // R9: strobes, compared on every clock by the monitor
    wr(10, 32'h5);
    idle();
    wr(11, 32'h3_0000);
    wr(12, 32'h2);
    rd("R9 read has no strobe", 12);
    idle();

    // R8: control register
    wr(0, 32'hFFFF_FFFF);
    rd("R8 ctrl read", 0);
    chk("R8 ctrl value", bus_rdata, 32'h1);
    wr(0, 32'h0);
    rd("R8 ctrl cleared", 0);

    // R11: busy readback
    ch_busy = 18'h2_0401;
    rd("R11 busy", 4);
    chk("R11 busy value", bus_rdata, 32'h0002_0401);

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      int a;
      logic [31:0] wd;
      a  = $urandom_range(0, 15);
      wd = $urandom;
      ch_busy = 18'($urandom);
      if ($urandom_range(0, 1) == 1)
        cyc(1, 1, a, wd, 18'($urandom & $urandom), 18'($urandom & $urandom),
            18'($urandom & $urandom & $urandom));
      else begin
        cyc(1, 0, a, 0, 18'($urandom & $urandom), 0, 0);
        #0.5;
        chk("R4 R10 mixed read", bus_rdata, m_read(a));
      end
    end
    idle();
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule